// File: doc/BRIEF.md
# Bit-Settable Coefficient Memory with Working Register File

This block holds a small one-time-settable memory of eight 16-bit words and the eight working registers that a compensation datapath reads. The memory can be wiped to all zeros as a whole, or have one addressed bit forced to 1. There is no way to clear a single bit. Each of these two operations holds a busy window whose length in clock cycles is a parameter. It stands for the several milliseconds that a real array write needs.

The working registers can be written directly by a test controller. They can also be refilled from the memory, one word per cycle, before a conversion is allowed to start. In test mode a conversion request picks whether the refill happens. In normal mode every conversion request refills the registers. The conversion strobe to the datapath leaves the block only once the refill has finished. Requests that arrive while an operation or a refill is still running are dropped, and each one raises a one-cycle error pulse.

Top module: `coef_store`

## Requirements
- R1: Bit address b (0 to 127) selects bit b mod 16 of word b div 16. A refill copies memory word k into working register k for k = 0..7, and word 0 is the configuration word.
- R2: An accepted bit-set request forces the addressed bit to 1 and leaves every other bit unchanged. Setting a bit that is already 1 leaves it at 1, and no request can clear a single bit.
- R3: An accepted erase request clears all 128 memory bits to 0. If erase and bit-set are requested in the same cycle, erase wins.
- R4: `busy` rises in the cycle after an accepted erase or bit-set and stays high for exactly BUSY_CYCLES cycles.
- R5: An erase, bit-set, register write or conversion request that arrives while `busy` or `loading` is high has no effect, and `err` is high for one cycle in the following cycle.
- R6: While `rst_n` is low, all working registers read 0. The memory contents survive reset.
- R7: With `test_en`=1, a conversion request with `conv_reload`=1 makes `loading` high for 8 cycles starting in the next cycle. `conv_start` pulses for one cycle right after `loading` falls, and by then the registers equal the memory words.
- R8: With `test_en`=1, a conversion request with `conv_reload`=0 leaves the registers unchanged, and `conv_start` pulses in the next cycle.
- R9: With `test_en`=0, every conversion request refills the registers as in R7, whatever the value of `conv_reload`.
- R10: An accepted register write puts `reg_wdata` into register `reg_addr` by the next cycle, as read through `rd_addr`/`rd_data`. The memory is not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; clears the working registers |
| test_en | input | 1 | 1 = test mode, 0 = normal mode |
| erase_req | input | 1 | Erase the whole memory to 0 |
| bitset_req | input | 1 | Set the memory bit at `bit_addr` to 1 |
| bit_addr | input | 7 | Memory bit address |
| reg_wr | input | 1 | Direct working-register write |
| reg_addr | input | 3 | Register write address |
| reg_wdata | input | 16 | Register write data |
| conv_req | input | 1 | Conversion request |
| conv_reload | input | 1 | In test mode, refill registers from memory before conversion |
| rd_addr | input | 3 | Working-register read address |
| rd_data | output | 16 | Working-register read data |
| busy | output | 1 | Memory operation in progress |
| loading | output | 1 | Register refill in progress |
| conv_start | output | 1 | One-cycle conversion strobe to the datapath |
| err | output | 1 | One-cycle pulse for a dropped request |

## Verification
The bench builds the block with BUSY_CYCLES = 20. This shrinks the millisecond-scale busy window to a length that allows dozens of bit-set operations in one short run. It also makes the exact busy length countable, and gives enough time to inject colliding requests inside the window. The word count and width stay at their defaults of 8 and 16, so that bit addresses 0x00 and 0x7F and the full 8-cycle refill are reached directly.

// File: rtl/coef_store.sv
module coef_store #(
  parameter int WORDS       = 8,
  parameter int WIDTH       = 16,
  parameter int BUSY_CYCLES = 12000
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             test_en,
  input  logic                             erase_req,
  input  logic                             bitset_req,
  input  logic [$clog2(WORDS*WIDTH)-1:0]   bit_addr,
  input  logic                             reg_wr,
  input  logic [$clog2(WORDS)-1:0]         reg_addr,
  input  logic [WIDTH-1:0]                 reg_wdata,
  input  logic                             conv_req,
  input  logic                             conv_reload,
  input  logic [$clog2(WORDS)-1:0]         rd_addr,
  output logic [WIDTH-1:0]                 rd_data,
  output logic                             busy,
  output logic                             loading,
  output logic                             conv_start,
  output logic                             err
);
  localparam int BITS  = WORDS * WIDTH;
  localparam int RA_W  = $clog2(WORDS);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] BUSY_LOAD = CNT_W'(BUSY_CYCLES);
  localparam logic [RA_W-1:0]  LAST_IDX  = RA_W'(WORDS - 1);

  logic [BITS-1:0]  mem;
  logic [WIDTH-1:0] regs [WORDS];
  logic [CNT_W-1:0] busy_cnt;
  logic [RA_W-1:0]  ld_idx;

  wire blocked   = busy | loading;
  wire any_req   = erase_req | bitset_req | reg_wr | conv_req;
  wire erase_go  = erase_req & ~blocked;
  wire set_go    = bitset_req & ~erase_req & ~blocked;
  wire wr_go     = reg_wr & ~blocked;
  wire conv_go   = conv_req & ~blocked;
  wire reload_go = conv_go & (conv_reload | ~test_en);
  wire load_last = loading && (ld_idx == LAST_IDX);

  assign busy    = (busy_cnt != '0);
  assign rd_data = regs[rd_addr];

  always_ff @(posedge clk) begin
    if (erase_go)    mem <= '0;
    else if (set_go) mem[bit_addr] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 busy_cnt <= '0;
    else if (erase_go | set_go) busy_cnt <= BUSY_LOAD;
    else if (busy)              busy_cnt <= busy_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loading <= 1'b0;
      ld_idx  <= '0;
    end else if (reload_go) begin
      loading <= 1'b1;
      ld_idx  <= '0;
    end else if (loading) begin
      if (load_last) loading <= 1'b0;
      ld_idx <= ld_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) regs[i] <= '0;
    end else if (loading) begin
      regs[ld_idx] <= mem[ld_idx*WIDTH +: WIDTH];
    end else if (wr_go) begin
      regs[reg_addr] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_start <= 1'b0;
      err        <= 1'b0;
    end else begin
      conv_start <= (conv_go & ~reload_go) | load_last;
      err        <= any_req & blocked;
    end
  end

  logic regs_any;
  always_comb begin
    regs_any = 1'b0;
    for (int i = 0; i < WORDS; i++) regs_any = regs_any | (|regs[i]);
  end

  a_r2_no_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(erase_go) |-> ((mem & $past(mem)) == $past(mem)));
  a_r4_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
    ((erase_req | bitset_req) && !blocked) |=> busy);
  a_r5_err_on_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (any_req && blocked) |=> err);
  a_r5_mem_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> $stable(mem));
  a_r6_regs_cleared: assert property (@(posedge clk)
    !rst_n |=> !regs_any);
  a_r7_start_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loading) |-> conv_start);
endmodule

// File: tb/coef_store_bench.sv
module coef_store_bench;
  localparam int WORDS = 8, WIDTH = 16, BUSY = 20;

  logic clk = 0, rst_n = 0, test_en = 1;
  logic erase_req = 0, bitset_req = 0, reg_wr = 0, conv_req = 0, conv_reload = 0;
  logic [6:0] bit_addr = '0;
  logic [2:0] reg_addr = '0, rd_addr = '0;
  logic [15:0] reg_wdata = '0, rd_data;
  logic busy, loading, conv_start, err;

  coef_store #(.WORDS(WORDS), .WIDTH(WIDTH), .BUSY_CYCLES(BUSY)) u_coef_store (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .erase_req(erase_req),
    .bitset_req(bitset_req), .bit_addr(bit_addr), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .conv_req(conv_req),
    .conv_reload(conv_reload), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .loading(loading), .conv_start(conv_start), .err(err));

  always #2 clk = ~clk;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic [127:0] m_mem = '0;
  logic [15:0]  m_reg [8];

  function automatic logic [15:0] mem_word(input logic [127:0] m, input int k);
    return m[k*16 +: 16];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    erase_req = 0; bitset_req = 0; reg_wr = 0; conv_req = 0;
  endtask

  task automatic wait_idle();
    while (busy || loading) @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < 8; i++) begin
      rd_addr = 3'(i); #1;
      check(rd_data === m_reg[i], req, rd_data, m_reg[i]);
    end
  endtask

  task automatic mem_op(input bit is_erase, input logic [6:0] a, input bit check_len);
    int n = 0;
    @(negedge clk);
    if (is_erase) erase_req = 1; else begin bitset_req = 1; bit_addr = a; end
    @(negedge clk); idle_inputs();
    if (is_erase) m_mem = '0; else m_mem[a] = 1'b1;
    if (check_len) begin
      while (busy) begin n++; @(negedge clk); end
      check(n == BUSY, "R4 busy length", n, BUSY);
    end else wait_idle();
  endtask

  task automatic conv(input bit reload_expected, input bit rl);
    int n = 0;
    @(negedge clk); conv_req = 1; conv_reload = rl;
    @(negedge clk); idle_inputs();
    if (reload_expected) begin
      while (loading) begin n++; @(negedge clk); end
      check(n == 8, "R7 load length", n, 8);
      check(conv_start === 1'b1, "R7 conv_start after load", conv_start, 1);
      for (int i = 0; i < 8; i++) m_reg[i] = mem_word(m_mem, i);
    end else begin
      check(loading === 1'b0, "R8 no load", loading, 0);
      check(conv_start === 1'b1, "R8 conv_start next cycle", conv_start, 1);
    end
    @(negedge clk);
    check(conv_start === 1'b0, "R7 conv_start single", conv_start, 0);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); idle_inputs();
    m_reg[a] = d;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    check_regs("R6 reset clears regs");
    check(busy === 1'b0, "R4 idle after reset", busy, 0);
    rst_n = 1;

    mem_op(1, '0, 1);
    check(err === 1'b0, "R5 no err on accepted", err, 0);

    // R5: bit-set and register write inside busy window are dropped
    @(negedge clk); erase_req = 1;
    @(negedge clk); idle_inputs(); m_mem = '0;
    repeat (3) @(negedge clk);
    bitset_req = 1; bit_addr = 7'h05;
    @(negedge clk); idle_inputs();
    check(err === 1'b1, "R5 err on blocked bitset", err, 1);
    @(negedge clk);
    check(err === 1'b0, "R5 err one cycle", err, 0);
    reg_wr = 1; reg_addr = 3'd2; reg_wdata = 16'hBEEF;
    @(negedge clk); idle_inputs();
    check(err === 1'b1, "R5 err on blocked write", err, 1);
    wait_idle();
    check_regs("R5 blocked write ignored");
    conv(1, 1);
    check_regs("R5 blocked bitset ignored");

    // R1/R2: directed corners and random bit addresses
    mem_op(0, 7'h00, 1);
    mem_op(0, 7'h7F, 0);
    mem_op(0, 7'h10, 0);
    for (int k = 0; k < 24; k++) mem_op(0, 7'($urandom_range(0, 127)), 0);
    mem_op(0, 7'h7F, 0);
    conv(1, 1);
    check_regs("R1 R2 reload matches memory");

    // R3: erase and bit-set in the same cycle, erase wins
    @(negedge clk); erase_req = 1; bitset_req = 1; bit_addr = 7'h21;
    @(negedge clk); idle_inputs(); m_mem = '0;
    wait_idle();
    conv(1, 1);
    check_regs("R3 erase clears all");

    // R10: direct writes, random data
    for (int k = 0; k < 8; k++) reg_write(3'(k), 16'($urandom));
    check_regs("R10 direct write");
    // R8: conversion without reload keeps registers
    mem_op(0, 7'h33, 0);
    conv(0, 0);
    check_regs("R8 regs unchanged");

    // R5: write during loading ignored
    @(negedge clk); conv_req = 1; conv_reload = 1;
    @(negedge clk); idle_inputs();
    reg_wr = 1; reg_addr = 3'd3; reg_wdata = 16'h1234;
    @(negedge clk); idle_inputs();
    check(err === 1'b1, "R5 err during load", err, 1);
    wait_idle();
    for (int i = 0; i < 8; i++) m_reg[i] = mem_word(m_mem, i);
    @(negedge clk);
    check_regs("R5 write during load ignored");

    // R6: reset clears regs, memory kept; R9 normal-mode reload
    rst_n = 0; @(negedge clk);
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    check_regs("R6 regs cleared");
    rst_n = 1; test_en = 0;
    conv(1, 0);
    check_regs("R9 normal mode reload");
    test_en = 1;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule